// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

This block is a synchronous on-chip SRAM with a pipelined command path. The complete word address arrives in one cycle, together with a read or write command and per-byte enables. There is no row phase and no column phase. A read returns its word on `rd_data` a fixed `LAT` clock cycles after the command. A write expects its data on `wr_data` exactly `LAT` cycles after the command. Because both directions use the same delay, a stream of commands can switch between reading and writing on every clock, and the data bus never needs a turnaround gap.

One command with `cmd_burst` set produces a sequence of `BURST_LEN` word accesses. The internal address steps through an aligned block and wraps around inside it. A new command that arrives while a burst is still running cancels the beats that remain. A write's data reaches the array only `LAT` cycles after its command. During that window, a read of the same address takes the pending data from a forwarding path, so every read sees all writes issued before it.

Top module: `lwsr_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_valid` is 0 and `rd_data` is 0. Beats still in flight when reset is asserted are discarded, including any burst continuations, and produce no read result.
- R2: A read beat issued in cycle t drives `rd_valid` high and its word on `rd_data` in cycle t+`LAT` (default 2). In every cycle that carries no read result, `rd_valid` is low.
- R3: A write beat issued in cycle t takes its data from `wr_data` in cycle t+`LAT` and stores it at the address captured in cycle t.
- R4: Byte enable bit i selects `wr_data[8i+7:8i]`. Only the enabled bytes of the addressed word change, and the other bytes keep their old value.
- R5: A read command with `cmd_burst`=1 issues `BURST_LEN` (default 4) beats on consecutive cycles. Each beat adds one, modulo `BURST_LEN`, to the low log2(`BURST_LEN`) address bits. The upper address bits stay fixed, so the sequence wraps inside the aligned block.
- R6: A write command with `cmd_burst`=1 takes its data on `BURST_LEN` consecutive cycles, starting `LAT` cycles after the command. The words go to the addresses in the same wrapped order as in R5, and every beat uses the byte enables of the command.
- R7: If `cmd_valid` is high while a burst still has beats to issue, the new command is issued in that cycle and the unissued beats of the old burst are dropped.
- R8: A read returns the word as it stands after all writes issued before it, applied in issue order. This holds even when the data of those writes has not yet been stored, including data that arrives in the same cycle the read result is produced.
- R9: Commands may alternate between write and read on every cycle. Every read then produces its result in its own slot, and no idle cycle is needed.
- R10: A value on `wr_data` in a cycle that is not the data slot of a write beat changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_burst | input | 1 | 1 = burst of BURST_LEN beats, 0 = single beat |
| cmd_addr | input | ADDR_W | Full word address |
| cmd_be | input | DATA_W/8 | Byte enables for a write, bit i for byte i |
| wr_data | input | DATA_W | Late write data, sampled LAT cycles after the write beat |
| rd_valid | output | 1 | rd_data carries a read result this cycle |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench is built around the cycle in which a read result is formed while an earlier write to the same word is still being stored. In that one cycle, the array write and the forwarding merge act on the same address. This is provoked in two ways. In the first, a write is followed directly by a read of its address, so the write data sits on `wr_data` in the very cycle the read result is registered. In the second, the write comes two cycles ahead of the read, so the array read misses that write and the held copy of the last stored word must supply it. The bench also sends a new command in the slot of a burst continuation, so that cancellation and issue fall on the same cycle. Every result is judged against a model in the bench. In that model, a read sees each write issued before it, merged byte by byte, and an aborted burst leaves its result slots empty.

// File: rtl/lwsr_pkg.sv
package lwsr_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/lwsr_issue.sv
// Picks the beat issued each cycle: a new command, or the next burst step.
module lwsr_issue
  import lwsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BE_W      = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_burst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BE_W-1:0]   cmd_be,
  output logic              beat_valid,
  output op_e               beat_op,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [BE_W-1:0]   beat_be
);
  localparam int OFS_W = $clog2(BURST_LEN);

  logic [OFS_W-1:0]  left_q;
  logic [ADDR_W-1:0] next_q;
  op_e               op_q;
  logic [BE_W-1:0]   be_q;

  function automatic logic [ADDR_W-1:0] wrap_step(input logic [ADDR_W-1:0] a);
    wrap_step = {a[ADDR_W-1:OFS_W], a[OFS_W-1:0] + 1'b1};
  endfunction

  always_comb begin
    beat_valid = 1'b0;
    beat_op    = op_q;
    beat_addr  = next_q;
    beat_be    = be_q;
    if (cmd_valid) begin
      beat_valid = 1'b1;
      beat_op    = cmd_write ? OP_WR : OP_RD;
      beat_addr  = cmd_addr;
      beat_be    = cmd_be;
    end else if (left_q != '0) begin
      beat_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      next_q <= '0;
      op_q   <= OP_RD;
      be_q   <= '0;
    end else if (cmd_valid) begin
      left_q <= cmd_burst ? OFS_W'(BURST_LEN - 1) : '0;
      next_q <= wrap_step(cmd_addr);
      op_q   <= cmd_write ? OP_WR : OP_RD;
      be_q   <= cmd_be;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      next_q <= wrap_step(next_q);
    end
  end
endmodule

// File: rtl/lwsr_pipe.sv
// LAT-stage command delay line; stage k holds the beat issued k+1 cycles ago.
module lwsr_pipe
  import lwsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 4,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  output logic [LAT-1:0]    st_valid,
  output op_e               st_op   [LAT],
  output logic [ADDR_W-1:0] st_addr [LAT],
  output logic [BE_W-1:0]   st_be   [LAT]
);
  always_ff @(posedge clk) begin
    if (rst) st_valid <= '0;
    else     st_valid <= {st_valid[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    st_op[0]   <= in_op;
    st_addr[0] <= in_addr;
    st_be[0]   <= in_be;
    for (int k = 1; k < LAT; k++) begin
      st_op[k]   <= st_op[k-1];
      st_addr[k] <= st_addr[k-1];
      st_be[k]   <= st_be[k-1];
    end
  end
endmodule

// File: rtl/lwsr_array.sv
// Byte-writable storage with a registered read-first port.
module lwsr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BE_W  = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/lwsr_merge.sv
// Forwards writes the array read could not see, then registers the result.
module lwsr_merge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rq_valid,
  input  logic [ADDR_W-1:0]   rq_addr,
  input  logic [DATA_W-1:0]   rd_word,
  input  logic                commit_en,
  input  logic [ADDR_W-1:0]   commit_addr,
  input  logic [DATA_W/8-1:0] commit_be,
  input  logic [DATA_W-1:0]   commit_data,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int BE_W = DATA_W / 8;

  logic              held_v;
  logic [ADDR_W-1:0] held_addr;
  logic [BE_W-1:0]   held_be;
  logic [DATA_W-1:0] held_data;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (rst) held_v <= 1'b0;
    else     held_v <= commit_en;
    held_addr <= commit_addr;
    held_be   <= commit_be;
    held_data <= commit_data;
  end

  always_comb begin
    merged = rd_word;
    if (held_v && held_addr == rq_addr) begin
      for (int b = 0; b < BE_W; b++)
        if (held_be[b]) merged[b*8 +: 8] = held_data[b*8 +: 8];
    end
    if (commit_en && commit_addr == rq_addr) begin
      for (int b = 0; b < BE_W; b++)
        if (commit_be[b]) merged[b*8 +: 8] = commit_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rq_valid;
      if (rq_valid) rd_data <= merged;
    end
  end
endmodule

// File: rtl/lwsr_top.sv
module lwsr_top
  import lwsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LAT       = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic                cmd_burst,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W/8-1:0] cmd_be,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int BE_W = DATA_W / 8;
  localparam int TAP  = (LAT > 2) ? LAT - 3 : 0;

  logic              beat_valid;
  op_e               beat_op;
  logic              beat_is_wr;
  logic [ADDR_W-1:0] beat_addr;
  logic [BE_W-1:0]   beat_be;

  logic [LAT-1:0]    st_valid;
  op_e               st_op   [LAT];
  logic [ADDR_W-1:0] st_addr [LAT];
  logic [BE_W-1:0]   st_be   [LAT];

  logic              arr_rd_en;
  logic [ADDR_W-1:0] arr_rd_addr;
  logic [DATA_W-1:0] arr_word;
  logic              mem_we;
  logic              rq_valid;

  lwsr_issue #(.ADDR_W(ADDR_W), .BE_W(BE_W), .BURST_LEN(BURST_LEN)) u_issue (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .beat_valid(beat_valid), .beat_op(beat_op),
    .beat_addr(beat_addr), .beat_be(beat_be)
  );

  assign beat_is_wr = (beat_op == OP_WR);

  lwsr_pipe #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LAT(LAT)) u_pipe (
    .clk(clk), .rst(rst),
    .in_valid(beat_valid), .in_op(beat_op), .in_addr(beat_addr), .in_be(beat_be),
    .st_valid(st_valid), .st_op(st_op), .st_addr(st_addr), .st_be(st_be)
  );

  // Array read happens LAT-1 cycles before the result is due.
  if (LAT == 2) begin : g_tap_issue
    assign arr_rd_en   = beat_valid && !beat_is_wr;
    assign arr_rd_addr = beat_addr;
  end else begin : g_tap_pipe
    assign arr_rd_en   = st_valid[TAP] && (st_op[TAP] == OP_RD);
    assign arr_rd_addr = st_addr[TAP];
  end

  assign mem_we   = st_valid[LAT-1] && (st_op[LAT-1] == OP_WR);
  assign rq_valid = st_valid[LAT-2] && (st_op[LAT-2] == OP_RD);

  lwsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk),
    .rd_en(arr_rd_en), .rd_addr(arr_rd_addr),
    .wr_en(mem_we), .wr_addr(st_addr[LAT-1]), .wr_be(st_be[LAT-1]), .wr_data(wr_data),
    .rd_word(arr_word)
  );

  lwsr_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst),
    .rq_valid(rq_valid), .rq_addr(st_addr[LAT-2]), .rd_word(arr_word),
    .commit_en(mem_we), .commit_addr(st_addr[LAT-1]), .commit_be(st_be[LAT-1]),
    .commit_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/lwsr_chk.sv
module lwsr_chk #(
  parameter int ADDR_W    = 8,
  parameter int LAT       = 2,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic              cmd_burst,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rd_valid,
  input logic              beat_valid,
  input logic              beat_is_wr,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              mem_we
);
  localparam int OFS_W = $clog2(BURST_LEN);

  logic [LAT-1:0] cmd_rd_sh;
  logic [LAT-1:0] beat_rd_sh;
  logic [LAT-1:0] beat_wr_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_rd_sh  <= '0;
      beat_rd_sh <= '0;
      beat_wr_sh <= '0;
    end else begin
      cmd_rd_sh  <= {cmd_rd_sh[LAT-2:0],  cmd_valid && !cmd_write};
      beat_rd_sh <= {beat_rd_sh[LAT-2:0], beat_valid && !beat_is_wr};
      beat_wr_sh <= {beat_wr_sh[LAT-2:0], beat_valid && beat_is_wr};
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_valid);

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rd_sh[LAT-1] |-> rd_valid);

  // R2
  read_only_when_due_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> beat_rd_sh[LAT-1]);

  // R3
  late_write_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we == beat_wr_sh[LAT-1]);

  // R5
  burst_wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_burst) ##1 !cmd_valid |->
      beat_valid
      && beat_addr[OFS_W-1:0] == OFS_W'($past(cmd_addr[OFS_W-1:0]) + 1'b1)
      && beat_addr[ADDR_W-1:OFS_W] == $past(cmd_addr[ADDR_W-1:OFS_W]));

  // R7
  single_no_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_burst) ##1 !cmd_valid |-> !beat_valid);
endmodule

bind lwsr_top lwsr_chk #(.ADDR_W(ADDR_W), .LAT(LAT), .BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst(rst),
  .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
  .cmd_addr(cmd_addr), .rd_valid(rd_valid),
  .beat_valid(beat_valid), .beat_is_wr(beat_is_wr), .beat_addr(beat_addr),
  .mem_we(mem_we)
);

// File: tb/tb_lwsr_top.sv
module tb_lwsr_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int LAT        = 2;
  localparam int BLEN       = 4;
  localparam int NROWS      = 52;
  localparam int HIST       = 64;
  localparam int WDOG       = 20000;

  typedef struct packed {
    logic        v;
    logic        w;
    logic        b;
    logic [7:0]  a;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [3:0]  tag;
  } vec_t;

  // One row per cycle: command fields, the wr_data driven that cycle, check tag.
  localparam vec_t TBL [NROWS] = '{
    '{1'b1,1'b1,1'b0,8'h10,4'hF,32'hDEAD0000,4'd3},
    '{1'b1,1'b1,1'b0,8'h11,4'hF,32'hDEAD0001,4'd3},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h11110000,4'd3},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h22220000,4'd3},
    '{1'b1,1'b0,1'b0,8'h10,4'hF,32'hAAAAAAAA,4'd3},
    '{1'b1,1'b0,1'b0,8'h11,4'hF,32'h55555555,4'd10},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h12345678,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b1,1'b0,8'h10,4'h5,32'h00000000,4'd4},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hFFFFFFFF,4'd4},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hABCDEF01,4'd4},
    '{1'b1,1'b0,1'b0,8'h10,4'hF,32'h00000000,4'd4},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b1,1'b1,8'h1E,4'hF,32'h00000000,4'd6},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd6},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hB0B0B0B0,4'd6},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hB1B1B1B1,4'd6},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hB2B2B2B2,4'd6},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'hB3B3B3B3,4'd6},
    '{1'b1,1'b0,1'b1,8'h1D,4'hF,32'h00000000,4'd5},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b0,1'b1,8'h1C,4'hF,32'h00000000,4'd7},
    '{1'b1,1'b0,1'b0,8'h10,4'hF,32'h00000000,4'd7},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd7},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd7},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b1,1'b0,8'h40,4'hF,32'h00000000,4'd8},
    '{1'b1,1'b0,1'b0,8'h40,4'hF,32'h00000000,4'd8},
    '{1'b1,1'b1,1'b0,8'h40,4'h3,32'hC0C0C0C0,4'd8},
    '{1'b1,1'b0,1'b0,8'h40,4'hF,32'h77777777,4'd8},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h0000D1D2,4'd8},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b1,1'b0,8'h44,4'hF,32'h00000000,4'd8},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b0,1'b0,8'h44,4'hF,32'h5A5A5A5A,4'd8},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b1,1'b1,1'b0,8'h50,4'hF,32'h00000000,4'd9},
    '{1'b1,1'b0,1'b0,8'h10,4'hF,32'h00000000,4'd9},
    '{1'b1,1'b1,1'b0,8'h51,4'hF,32'h50505050,4'd9},
    '{1'b1,1'b0,1'b0,8'h50,4'hF,32'h99999999,4'd9},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h51515151,4'd9},
    '{1'b1,1'b0,1'b0,8'h51,4'hF,32'h00000000,4'd9},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0},
    '{1'b0,1'b0,1'b0,8'h00,4'h0,32'h00000000,4'd0}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_valid, cmd_write, cmd_burst;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BE_W-1:0]   cmd_be;
  logic [DATA_W-1:0] wr_data;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [DATA_W-1:0] mmem [1 << ADDR_W];
  logic              hv   [HIST];
  logic              hw   [HIST];
  logic [ADDR_W-1:0] ha   [HIST];
  logic [BE_W-1:0]   hbe  [HIST];
  logic [3:0]        htag [HIST];

  lwsr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .BURST_LEN(BLEN)) dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd1:    tagname = "R1";
      4'd3:    tagname = "R3";
      4'd4:    tagname = "R4";
      4'd5:    tagname = "R5 R6";
      4'd6:    tagname = "R6";
      4'd7:    tagname = "R7";
      4'd8:    tagname = "R8";
      4'd9:    tagname = "R9";
      4'd10:   tagname = "R10";
      default: tagname = "R2";
    endcase
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] a);
    wrap_next = {a[ADDR_W-1:2], a[1:0] + 2'd1};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int                mleft;
    logic [ADDR_W-1:0] mnext;
    logic              mw;
    logic [BE_W-1:0]   mbe;
    logic [3:0]        mtag;
    vec_t              r;

    for (int i = 0; i < (1 << ADDR_W); i++) mmem[i] = '0;
    for (int i = 0; i < HIST; i++) begin
      hv[i] = 1'b0; hw[i] = 1'b0; ha[i] = '0; hbe[i] = '0; htag[i] = '0;
    end
    mleft = 0; mnext = '0; mw = 1'b0; mbe = '0; mtag = '0;

    rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_burst = 1'b0;
    cmd_addr = '0; cmd_be = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'h0);
    check(rd_data == '0, "R1", rd_data, 32'h0);
    rst = 1'b0;

    for (int c = 0; c < NROWS; c++) begin
      // result due this cycle belongs to the beat issued LAT cycles ago
      if (c >= LAT) begin
        int p;
        p = (c - LAT) % HIST;
        if (hv[p] && !hw[p]) begin
          check(rd_valid == 1'b1, tagname(htag[p]), 32'(rd_valid), 32'h1);
          check(rd_data == mmem[ha[p]], tagname(htag[p]), rd_data, mmem[ha[p]]);
        end else begin
          check(rd_valid == 1'b0, tagname(htag[p]), 32'(rd_valid), 32'h0);
        end
      end
      r = TBL[c];
      // late data of the write beat issued LAT cycles ago
      if (c >= LAT) begin
        int p;
        p = (c - LAT) % HIST;
        if (hv[p] && hw[p])
          for (int b = 0; b < BE_W; b++)
            if (hbe[p][b]) mmem[ha[p]][b*8 +: 8] = r.wd[b*8 +: 8];
      end
      // beat issued this cycle
      begin
        int q;
        q = c % HIST;
        if (r.v) begin
          hv[q] = 1'b1; hw[q] = r.w; ha[q] = r.a; hbe[q] = r.be; htag[q] = r.tag;
          mleft = r.b ? BLEN - 1 : 0;
          mnext = wrap_next(r.a); mw = r.w; mbe = r.be; mtag = r.tag;
        end else if (mleft > 0) begin
          hv[q] = 1'b1; hw[q] = mw; ha[q] = mnext; hbe[q] = mbe; htag[q] = mtag;
          mnext = wrap_next(mnext);
          mleft--;
        end else begin
          hv[q] = 1'b0; hw[q] = 1'b0; htag[q] = r.tag;
        end
      end
      cmd_valid = r.v; cmd_write = r.w; cmd_burst = r.b;
      cmd_addr = r.a; cmd_be = r.be; wr_data = r.wd;
      @(negedge clk);
    end

    // R1: reset lands while a burst read is running
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_burst = 1'b1; cmd_addr = 8'h1C; cmd_be = '1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_burst = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rd_data == '0, "R1", rd_data, 32'h0);
    for (int k = 0; k < 6; k++) begin
      check(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'h0);
      @(negedge clk);
    end

    // R8: stored words are intact after reset (read of 0x44)
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 8'h44;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b1, "R8", 32'(rd_valid), 32'h1);
    check(rd_data == 32'h5A5A5A5A, "R8", rd_data, 32'h5A5A5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule